// File: doc/BRIEF.md
# Synthesizer Divider and Phase Detector Core

This block is the digital heart of an integer-N frequency synthesizer. The RF signal has already been divided by eight ahead of the block. Each rising edge of that prescaled signal reaches the core as a one-cycle strobe on `rfTick`. A 15-bit programmable counter divides this stream by a ratio N. A second counter divides the crystal strobe stream `refTick` by a selectable reference ratio of 640, 512 or 1024. Both strobes are sampled in the core clock domain.

The two divided pulses feed a three-state phase-frequency detector. Its state drives three outputs: pump-up, pump-down and pump-off (high impedance). A test code can override these outputs to force the high-impedance, sinking or sourcing condition. The pump current selection flag passes straight through to the analog pump. The pump, the prescaler and the oscillator lie outside this block.

Top module: `pll_synth_core`

## Requirements
- R1: After reset the first `rfTick` produces a `rfDivPulse`, and after that one pulse follows every N-th `rfTick`. Each pulse lasts one clock and appears in the clock after the posedge that sampled the tick.
- R2: A `divRatio` value below 256 is treated as 256.
- R3: A new `divRatio` is taken only when the counter reloads, on the tick that produces a pulse. The period already in progress keeps the old ratio.
- R4: `refSel` picks the reference ratio, sampled at each reload. `refSel[1]=0` gives 640, `2'b11` gives 512 and `2'b10` gives 1024. The first `refTick` after reset produces a `refDivPulse`, and the pulse timing follows R1.
- R5: In the clock after a `refDivPulse`, the detector raises its up state. In the clock after a `rfDivPulse`, it raises its down state. When both states would be set at once, both clear, so coincident pulses leave the detector idle.
- R6: The up and down states are never active together.
- R7: `testMode` is 3 bits, written as the concatenation {b2,b1,b0}. The code `3'b101` forces `pumpOff=1` with up and down low. `3'b110` forces `pumpDn=1` alone, and `3'b111` forces `pumpUp=1` alone. Any code with b2=0, and `3'b100`, gives normal detector output.
- R8: In normal output mode, `pumpOff` is high exactly when neither detector state is active. Exactly one of `pumpUp`, `pumpDn` and `pumpOff` is high at all times.
- R9: `pumpHighCurrent` equals `cpNormal` at all times.
- R10: While `rstN` is low, `pumpOff=1`, `pumpUp=0`, `pumpDn=0`, and both divided pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| rfTick | input | 1 | Strobe for each prescaled RF edge |
| refTick | input | 1 | Strobe for each crystal edge |
| divRatio | input | 15 | Programmable divide ratio N |
| refSel | input | 2 | Reference ratio select |
| testMode | input | 3 | Pump output override code |
| cpNormal | input | 1 | Pump current select (1 = normal current) |
| pumpUp | output | 1 | Pump source enable |
| pumpDn | output | 1 | Pump sink enable |
| pumpOff | output | 1 | Pump high-impedance enable |
| pumpHighCurrent | output | 1 | Pump current select, passed through |
| rfDivPulse | output | 1 | Divided RF pulse |
| refDivPulse | output | 1 | Divided reference pulse |

## Verification
The hardest situations to reach are the detector states that need a phase offset between the two divided pulses. Every such state sits hundreds of strobes behind a reload, and a ratio change mid-period only shows at the next reload. The stimulus runs long stretches with both strobes active, then stretches with only the reference strobe or only the RF strobe. This pulls the dividers apart, so the up and down states persist, clear together, and line up again. Ratio writes are placed in the middle of a period so that the old and new ratios can be told apart.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;
  localparam int DIV_W = 15;
  localparam int REF_W = 11;

  typedef struct packed {
    logic rfEdge;
    logic refEdge;
  } div_strobe_t;

  typedef struct packed {
    logic [DIV_W-1:0] rfLoad;
    logic [REF_W-1:0] refLoad;
  } div_load_t;

  typedef enum logic [1:0] {
    DRV_NORMAL,
    DRV_HIZ,
    DRV_SINK,
    DRV_SOURCE
  } drive_mode_e;
endpackage

// File: rtl/pll_div_counter.sv
module pll_div_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [CNT_W-1:0] loadVal,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;

  // A count of 0 (after reset) or 1 means the next tick ends the period.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt < CNT_W'(2)) begin
          cnt   <= loadVal;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  p_pulse_from_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> $past(tick));
  p_pulse_isolated_r1: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);
endmodule

// File: rtl/pll_core_dp.sv
module pll_core_dp
  import pll_core_pkg::*;
#(
  parameter int MIN_DIV = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rfTick,
  input  logic        refTick,
  input  div_load_t   loads,
  output div_strobe_t strobes
);
  pll_div_counter #(.CNT_W(DIV_W)) u_rfDiv (
    .clk(clk), .rstN(rstN), .tick(rfTick),
    .loadVal(loads.rfLoad), .pulse(strobes.rfEdge)
  );

  pll_div_counter #(.CNT_W(REF_W)) u_refDiv (
    .clk(clk), .rstN(rstN), .tick(refTick),
    .loadVal(loads.refLoad), .pulse(strobes.refEdge)
  );

  p_load_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    loads.rfLoad >= DIV_W'(MIN_DIV));
endmodule

// File: rtl/pll_core_ctl.sv
module pll_core_ctl
  import pll_core_pkg::*;
#(
  parameter int MIN_DIV  = 256,
  parameter int REF_DEF  = 640,
  parameter int REF_ALT  = 512,
  parameter int REF_LONG = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [1:0]       refSel,
  input  logic [2:0]       testMode,
  input  div_strobe_t      strobes,
  output div_load_t        loads,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             pumpOff
);
  localparam logic [DIV_W-1:0] DivFloor = DIV_W'(MIN_DIV);

  logic        upQ, dnQ;
  logic        upNext, dnNext;
  drive_mode_e driveMode;

  // Reload values presented to the datapath
  always_comb begin
    loads.rfLoad = (divRatio < DivFloor) ? DivFloor : divRatio;
    if (!refSel[1])     loads.refLoad = REF_W'(REF_DEF);
    else if (refSel[0]) loads.refLoad = REF_W'(REF_ALT);
    else                loads.refLoad = REF_W'(REF_LONG);
  end

  // Three-state phase-frequency detector
  always_comb begin
    upNext = upQ | strobes.refEdge;
    dnNext = dnQ | strobes.rfEdge;
    if (upNext && dnNext) begin
      upNext = 1'b0;
      dnNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else begin
      upQ <= upNext;
      dnQ <= dnNext;
    end
  end

  // Test override decode
  always_comb begin
    if (!testMode[2]) begin
      driveMode = DRV_NORMAL;
    end else begin
      case (testMode[1:0])
        2'b01:   driveMode = DRV_HIZ;
        2'b10:   driveMode = DRV_SINK;
        2'b11:   driveMode = DRV_SOURCE;
        default: driveMode = DRV_NORMAL;
      endcase
    end
  end

  always_comb begin
    case (driveMode)
      DRV_HIZ:    begin pumpUp = 1'b0; pumpDn = 1'b0; pumpOff = 1'b1; end
      DRV_SINK:   begin pumpUp = 1'b0; pumpDn = 1'b1; pumpOff = 1'b0; end
      DRV_SOURCE: begin pumpUp = 1'b1; pumpDn = 1'b0; pumpOff = 1'b0; end
      default:    begin pumpUp = upQ;  pumpDn = dnQ;  pumpOff = !(upQ || dnQ); end
    endcase
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(upQ && dnQ));
  p_one_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones({pumpUp, pumpDn, pumpOff}) == 1);
  p_force_hiz_r7: assert property (@(posedge clk) disable iff (!rstN)
    (testMode == 3'b101) |-> (pumpOff && !pumpUp && !pumpDn));
  p_ref_sets_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.refEdge && !strobes.rfEdge && !dnQ) |=> upQ);
  p_rf_sets_dn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rfEdge && !strobes.refEdge && !upQ) |=> dnQ);
  p_ref_ratio_legal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loads.refLoad == REF_W'(REF_DEF)) || (loads.refLoad == REF_W'(REF_ALT)) ||
    (loads.refLoad == REF_W'(REF_LONG)));
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_core_pkg::*;
#(
  parameter int MIN_DIV  = 256,
  parameter int REF_DEF  = 640,
  parameter int REF_ALT  = 512,
  parameter int REF_LONG = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rfTick,
  input  logic             refTick,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [1:0]       refSel,
  input  logic [2:0]       testMode,
  input  logic             cpNormal,
  output logic             pumpUp,
  output logic             pumpDn,
  output logic             pumpOff,
  output logic             pumpHighCurrent,
  output logic             rfDivPulse,
  output logic             refDivPulse
);
  div_strobe_t strobes;
  div_load_t   loads;

  pll_core_dp #(.MIN_DIV(MIN_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .rfTick(rfTick), .refTick(refTick),
    .loads(loads), .strobes(strobes)
  );

  pll_core_ctl #(
    .MIN_DIV(MIN_DIV), .REF_DEF(REF_DEF), .REF_ALT(REF_ALT), .REF_LONG(REF_LONG)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .divRatio(divRatio), .refSel(refSel),
    .testMode(testMode), .strobes(strobes), .loads(loads),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpOff(pumpOff)
  );

  assign pumpHighCurrent = cpNormal;
  assign rfDivPulse      = strobes.rfEdge;
  assign refDivPulse     = strobes.refEdge;
endmodule

// File: tb/sim_pll_synth_core.sv
`timescale 1ns/1ps
module sim_pll_synth_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rfTick = 1'b0, refTick = 1'b0;
  logic [14:0] divRatio = 15'd256;
  logic [1:0]  refSel = 2'b11;
  logic [2:0]  testMode = 3'b000;
  logic        cpNormal = 1'b1;
  logic        pumpUp, pumpDn, pumpOff, pumpHighCurrent, rfDivPulse, refDivPulse;

  int checks = 0;
  int fails = 0;
  string rfTag = "R1";

  bit rfQ[$];
  bit refQ[$];
  int rfIdx = 0, rfNext = 1, refIdx = 0, refNext = 1;
  bit prevRf = 0, prevRef = 0, expUp = 0, expDn = 0;

  always #10 clk = ~clk;

  pll_synth_core u0 (
    .clk(clk), .rstN(rstN), .rfTick(rfTick), .refTick(refTick),
    .divRatio(divRatio), .refSel(refSel), .testMode(testMode), .cpNormal(cpNormal),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpOff(pumpOff),
    .pumpHighCurrent(pumpHighCurrent), .rfDivPulse(rfDivPulse), .refDivPulse(refDivPulse)
  );

  function automatic int effN(logic [14:0] n);
    return (n < 15'd256) ? 256 : int'(n);
  endfunction

  function automatic int refRatio(logic [1:0] s);
    if (!s[1]) return 640;
    return s[0] ? 512 : 1024;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Driver: one step per clock, inputs change 2 ns after the posedge
  task automatic step(bit rf, bit rr);
    @(posedge clk);
    #2;
    rfTick  = rf;
    refTick = rr;
    if (rf) begin
      rfIdx++;
      if (rfIdx == rfNext) begin
        rfQ.push_back(1'b1);
        rfNext += effN(divRatio);
      end else begin
        rfQ.push_back(1'b0);
      end
    end
    if (rr) begin
      refIdx++;
      if (refIdx == refNext) begin
        refQ.push_back(1'b1);
        refNext += refRatio(refSel);
      end else begin
        refQ.push_back(1'b0);
      end
    end
  endtask

  task automatic run(int n, bit rf, bit rr);
    for (int i = 0; i < n; i++) step(rf, rr);
  endtask

  // Monitor: compares at the negedge
  always @(negedge clk) begin
    bit eRf, eRef, oUp, oDn, oOff, nu, nd;
    string pTag;
    if (!rstN) begin
      check("R10", "pumpOff", int'(pumpOff), 1);
      check("R10", "pumpUp", int'(pumpUp), 0);
      check("R10", "pumpDn", int'(pumpDn), 0);
      check("R10", "pulses", int'(rfDivPulse | refDivPulse), 0);
      expUp = 0; expDn = 0; prevRf = 0; prevRef = 0;
    end else begin
      eRf  = prevRf  ? rfQ.pop_front()  : 1'b0;
      eRef = prevRef ? refQ.pop_front() : 1'b0;
      check(rfTag, "rfDivPulse", int'(rfDivPulse), int'(eRf));
      check("R4", "refDivPulse", int'(refDivPulse), int'(eRef));
      pTag = "R5 R6 R8";
      oUp = expUp; oDn = expDn; oOff = !(expUp || expDn);
      if (testMode[2]) pTag = "R7";
      if (testMode == 3'b101) begin oUp = 0; oDn = 0; oOff = 1; end
      if (testMode == 3'b110) begin oUp = 0; oDn = 1; oOff = 0; end
      if (testMode == 3'b111) begin oUp = 1; oDn = 0; oOff = 0; end
      check(pTag, "pumpUp", int'(pumpUp), int'(oUp));
      check(pTag, "pumpDn", int'(pumpDn), int'(oDn));
      check(pTag, "pumpOff", int'(pumpOff), int'(oOff));
      check("R9", "pumpHighCurrent", int'(pumpHighCurrent), int'(cpNormal));
      nu = expUp | eRef;
      nd = expDn | eRf;
      if (nu && nd) begin nu = 0; nd = 0; end
      expUp = nu; expDn = nd;
      prevRf = rfTick; prevRef = refTick;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    run(4, 0, 0);
    rstN = 1'b1;
    // R1 with 512 reference: coincident start, then offsets
    run(600, 1, 1);
    // R2: ratio below floor, default 640 reference
    rfTag = "R2";
    divRatio = 15'd100;
    refSel = 2'b00;
    run(1400, 1, 1);
    // R3: mid-period ratio changes
    rfTag = "R3";
    divRatio = 15'd1000;
    run(300, 1, 1);
    divRatio = 15'd400;
    run(2500, 1, 1);
    // Detector with one side stalled
    rfTag = "R1";
    run(1500, 0, 1);
    run(1200, 1, 0);
    // R4: long reference ratio
    refSel = 2'b10;
    divRatio = 15'd777;
    run(2200, 1, 1);
    // R7 overrides and R9 pass-through
    testMode = 3'b101; run(300, 1, 1);
    testMode = 3'b110; cpNormal = 1'b0; run(300, 1, 0);
    testMode = 3'b111; run(300, 0, 1);
    testMode = 3'b100; cpNormal = 1'b1; run(300, 1, 1);
    testMode = 3'b011; run(300, 1, 1);
    testMode = 3'b000;
    refSel = 2'b01;
    run(800, 1, 1);
    run(3, 0, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule